// File: doc/BRIEF.md
# Double to Int32 Wrapping Converter

This block takes an IEEE-754 binary64 operand and returns a signed 32-bit integer. It always rounds toward zero and ignores any rounding-mode setting. When the truncated value does not fit in 32 signed bits, the block keeps only its low 32 bits and reads them as two's complement. It does not clamp to the nearest limit. This is the wrap-around convention that script engines use for their 32-bit integer coercion.

Next to the integer, the block returns a 4-bit condition nibble. Only one of its bits is ever set: an exactness flag, set when the conversion lost nothing. Two exception indications, invalid and inexact, also go out with each result.

Operands come in on a valid/ready request channel. Results leave on a valid/ready response channel, where the result, nibble and exception bits are registered together. The parameter `STAGES` selects the pipeline depth. With 1, a result is offered in the cycle after acceptance. With 2, an extra register is inserted between the shifter and the result packing. Decode, register files and trap routing belong to the surrounding core.

Top module: `f2i_wrap_conv`

## Requirements
- R1: A finite operand whose truncated value lies in [-2^31, 2^31-1] yields that truncated value (rounding toward zero) as a two's-complement number.
- R2: A finite operand whose truncated value falls outside [-2^31, 2^31-1] yields the truncated value modulo 2^32. For a negative operand, the magnitude is truncated first and its low 32 bits are then negated.
- R3: A NaN operand (exponent field all ones, fraction nonzero) yields result 0 with invalid set.
- R4: An infinite operand (exponent field all ones, fraction zero) of either sign yields result 0 with invalid set.
- R5: Bits 3, 1 and 0 of the flag nibble are always 0.
- R6: Bit 2 of the flag nibble (exact flag) is 1 exactly when all of these hold: the operand is finite, truncation drops no nonzero fraction bit, the truncated value lies in the signed 32-bit range, and the operand is not negative zero.
- R7: Operands of magnitude below 1, including subnormals, yield result 0. Inexact is set when the operand is nonzero.
- R8: Finite operands with an unbiased exponent of 84 or more yield result 0 and set invalid.
- R9: Invalid is 1 exactly for NaN, infinity, or a finite operand out of the signed 32-bit range. Inexact is 1 exactly for a finite in-range operand whose truncation drops nonzero fraction bits. The two are never both set.
- R10: `in_ready` is high whenever the response slot is empty or being drained. With `STAGES`=1, an accepted operand is presented on the response channel one cycle later, back-to-back operands stream at one per cycle, and a presented response holds steady while `out_ready` is low.
- R11: While `rst_n` is low at a clock edge, the response channel is cleared (`out_valid`, result, nibble and exception bits all 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_op | input | 64 | binary64 operand |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 32 | Truncated, wrapped two's-complement integer |
| out_flags | output | 4 | Condition nibble; bit 2 is the exact flag |
| out_invalid | output | 1 | NaN, infinity or out-of-range operand |
| out_inexact | output | 1 | In-range operand lost fraction bits |

## Verification
Some operands hit the 32-bit boundary and drop fraction bits in the same conversion, so range classification and fraction loss fall in one cycle. Examples are -2^31-0.5 (in range, inexact), 2^31-0.5 (in range, inexact) and +2^31 (wrapped, invalid). The bench sweeps every exponent code with several fraction patterns and both signs, so the magnitude test and the fraction-loss test work on the same operand at every shift distance. Each result and flag set is compared against a bench model that places the significand in a wide fixed-point word and reads off the integer and fraction parts arithmetically. The same sweep also provokes the handshake and the conversion together: back pressure is applied while a converted result waits, and the result must stay unchanged until it is taken.

// File: rtl/f2i_pkg.sv
// Package f2i_pkg
// Shared defaults and the operand class type for the double to int32
// wrapping converter. Assumes binary64 default widths.
package f2i_pkg;
    localparam int F2I_EXP_W = 11;
    localparam int F2I_MAN_W = 52;
    localparam int F2I_INT_W = 32;
    localparam int F2I_FLAG_W = 4;
    localparam int F2I_Z_BIT = 2;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_SUB  = 3'd1,
        CL_NORM = 3'd2,
        CL_INF  = 3'd3,
        CL_NAN  = 3'd4
    } fclass_t;
endpackage

// File: rtl/f2i_classify.sv
// Module f2i_classify
// Splits a binary float into sign, class, unbiased exponent and the
// significand with its hidden bit. Purely combinational. Subnormals get
// the exponent of the zero code minus bias; they stay below one either way.
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W = F2I_EXP_W,
    parameter int MAN_W = F2I_MAN_W
) (
    input  logic [EXP_W+MAN_W:0]    op,
    output logic                    sign,
    output fclass_t                 cls,
    output logic signed [EXP_W+1:0] uexp,
    output logic [MAN_W:0]          sig
);
    localparam int UEXP_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_zero;
    logic             man_zero;

    assign sign     = op[EXP_W+MAN_W];
    assign exp_f    = op[MAN_W +: EXP_W];
    assign man_f    = op[MAN_W-1:0];
    assign exp_ones = &exp_f;
    assign exp_zero = ~|exp_f;
    assign man_zero = ~|man_f;

    // Class decode from the exponent and fraction field codes.
    always_comb begin
        if (exp_ones) begin
            cls = man_zero ? CL_INF : CL_NAN;
        end else if (exp_zero) begin
            cls = man_zero ? CL_ZERO : CL_SUB;
        end else begin
            cls = CL_NORM;
        end
    end

    // Unbiased exponent and significand with the hidden bit.
    always_comb begin
        uexp = $signed({2'b00, exp_f}) - $signed(UEXP_W'(BIAS));
        sig  = {~exp_zero, man_f};
    end
endmodule

// File: rtl/f2i_rshift.sv
// Module f2i_rshift
// Logarithmic right shifter that also reports whether any set bit fell
// off the bottom (sticky). Assumes amt is below W where it matters.
module f2i_rshift #(
    parameter int W   = 53,
    parameter int SHW = 6
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout,
    output logic           sticky
);
    // Shift by each power of two in turn, collecting the dropped bits.
    always_comb begin
        logic [W-1:0] d;
        logic         s;
        d = din;
        s = 1'b0;
        for (int k = 0; k < SHW; k++) begin
            if (amt[k]) begin
                s = s | (|(d & ((W'(1) << (1 << k)) - W'(1))));
                d = d >> (1 << k);
            end
        end
        dout   = d;
        sticky = s;
    end
endmodule

// File: rtl/f2i_truncate.sv
// Module f2i_truncate
// Turns significand and unbiased exponent into the low INT_W bits of the
// integer magnitude. It also reports lost fraction bits and whether the
// magnitude reaches 2^(INT_W-1). Assumes SIG_W > INT_W.
module f2i_truncate #(
    parameter int SIG_W  = 53,
    parameter int INT_W  = 32,
    parameter int UEXP_W = 13
) (
    input  logic [SIG_W-1:0]        sig,
    input  logic signed [UEXP_W-1:0] uexp,
    output logic [INT_W-1:0]        mag_low,
    output logic                    frac_lost,
    output logic                    mag_ge_half,
    output logic                    mag_eq_half
);
    localparam int FRAC_W = SIG_W - 1;
    localparam int WRAP_E = FRAC_W + INT_W;
    localparam int RSW    = $clog2(SIG_W);
    localparam int LSW    = $clog2(INT_W);
    localparam int WIDE_W = INT_W + SIG_W;
    localparam logic [SIG_W-1:0] HALF = SIG_W'(1) << (INT_W - 1);

    logic signed [UEXP_W-1:0] rsh_full;
    logic signed [UEXP_W-1:0] lsh_full;
    logic [RSW-1:0]           rsh;
    logic [LSW-1:0]           lsh;
    logic [SIG_W-1:0]         int_r;
    logic                     sticky_r;
    logic [WIDE_W-1:0]        wide_l;
    logic                     below_one;
    logic                     in_right;
    logic                     in_left;

    assign rsh_full  = $signed(UEXP_W'(FRAC_W)) - uexp;
    assign lsh_full  = uexp - $signed(UEXP_W'(FRAC_W));
    assign rsh       = rsh_full[RSW-1:0];
    assign lsh       = lsh_full[LSW-1:0];
    assign below_one = uexp < $signed(UEXP_W'(0));
    assign in_right  = !below_one && (uexp <= $signed(UEXP_W'(FRAC_W)));
    assign in_left   = (uexp > $signed(UEXP_W'(FRAC_W))) &&
                       (uexp < $signed(UEXP_W'(WRAP_E)));

    f2i_rshift #(.W(SIG_W), .SHW(RSW)) u_rshift (
        .din    (sig),
        .amt    (rsh),
        .dout   (int_r),
        .sticky (sticky_r)
    );

    // Left placement for exponents past the fraction width.
    assign wide_l = {{INT_W{1'b0}}, sig} << lsh;

    // Select the region by exponent: below one, right shift, left shift, all-out.
    always_comb begin
        mag_low     = '0;
        frac_lost   = 1'b0;
        mag_ge_half = 1'b1;
        mag_eq_half = 1'b0;
        if (below_one) begin
            frac_lost   = |sig;
            mag_ge_half = 1'b0;
        end else if (in_right) begin
            mag_low     = int_r[INT_W-1:0];
            frac_lost   = sticky_r;
            mag_ge_half = |int_r[SIG_W-1:INT_W-1];
            mag_eq_half = (int_r == HALF);
        end else if (in_left) begin
            mag_low = wide_l[INT_W-1:0];
        end
    end
endmodule

// File: rtl/f2i_pack.sv
// Module f2i_pack
// Applies the sign, the special-value rules and the range rule, and
// builds the result word, condition nibble and exception bits.
// Combinational; assumes the class code came from f2i_classify.
module f2i_pack
    import f2i_pkg::*;
#(
    parameter int INT_W  = F2I_INT_W,
    parameter int FLAG_W = F2I_FLAG_W,
    parameter int Z_BIT  = F2I_Z_BIT
) (
    input  logic              sign,
    input  fclass_t           cls,
    input  logic [INT_W-1:0]  mag_low,
    input  logic              frac_lost,
    input  logic              mag_ge_half,
    input  logic              mag_eq_half,
    output logic [INT_W-1:0]  result,
    output logic [FLAG_W-1:0] flags,
    output logic              invalid,
    output logic              inexact
);
    logic finite;
    logic fits;
    logic neg_zero;
    logic exact;

    // Range and classification terms.
    always_comb begin
        finite   = (cls == CL_ZERO) || (cls == CL_SUB) || (cls == CL_NORM);
        fits     = !mag_ge_half || (sign && mag_eq_half);
        neg_zero = sign && (cls == CL_ZERO);
        exact    = finite && fits && !frac_lost && !neg_zero;
    end

    // Result word: zero for specials, else the wrapped signed magnitude.
    always_comb begin
        if (!finite) begin
            result = '0;
        end else if (sign) begin
            result = '0 - mag_low;
        end else begin
            result = mag_low;
        end
    end

    // Condition nibble and exception indications.
    always_comb begin
        flags        = '0;
        flags[Z_BIT] = exact;
        invalid      = !finite || !fits;
        inexact      = finite && fits && frac_lost;
    end
endmodule

// File: rtl/f2i_wrap_conv.sv
// Module f2i_wrap_conv
// Top of the double to int32 wrapping converter. Request and response are
// valid/ready channels. STAGES=1 gives one register (response); STAGES=2
// adds a register after the shifter. Synchronous active-low reset.
module f2i_wrap_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W  = F2I_EXP_W,
    parameter int MAN_W  = F2I_MAN_W,
    parameter int INT_W  = F2I_INT_W,
    parameter int FLAG_W = F2I_FLAG_W,
    parameter int STAGES = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [EXP_W+MAN_W:0]   in_op,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [INT_W-1:0]       out_result,
    output logic [FLAG_W-1:0]      out_flags,
    output logic                   out_invalid,
    output logic                   out_inexact
);
    localparam int SIG_W  = MAN_W + 1;
    localparam int UEXP_W = EXP_W + 2;

    logic                     c_sign;
    fclass_t                  c_cls;
    logic signed [UEXP_W-1:0] c_uexp;
    logic [SIG_W-1:0]         c_sig;
    logic [INT_W-1:0]         t_mag;
    logic                     t_lost;
    logic                     t_ge;
    logic                     t_eq;

    logic                     m_valid;
    logic                     m_sign;
    fclass_t                  m_cls;
    logic [INT_W-1:0]         m_mag;
    logic                     m_lost;
    logic                     m_ge;
    logic                     m_eq;

    logic [INT_W-1:0]         p_result;
    logic [FLAG_W-1:0]        p_flags;
    logic                     p_invalid;
    logic                     p_inexact;
    logic                     out_slot_free;

    f2i_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
        .op   (in_op),
        .sign (c_sign),
        .cls  (c_cls),
        .uexp (c_uexp),
        .sig  (c_sig)
    );

    f2i_truncate #(.SIG_W(SIG_W), .INT_W(INT_W), .UEXP_W(UEXP_W)) u_truncate (
        .sig         (c_sig),
        .uexp        (c_uexp),
        .mag_low     (t_mag),
        .frac_lost   (t_lost),
        .mag_ge_half (t_ge),
        .mag_eq_half (t_eq)
    );

    assign out_slot_free = !out_valid || out_ready;

    generate
        if (STAGES >= 2) begin : g_mid_reg
            logic mid_free;
            assign mid_free = !m_valid || out_slot_free;
            assign in_ready = mid_free;

            // Middle register between the shifter and the result packing.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    m_valid <= 1'b0;
                    m_sign  <= 1'b0;
                    m_cls   <= CL_ZERO;
                    m_mag   <= '0;
                    m_lost  <= 1'b0;
                    m_ge    <= 1'b0;
                    m_eq    <= 1'b0;
                end else if (mid_free) begin
                    m_valid <= in_valid;
                    if (in_valid) begin
                        m_sign <= c_sign;
                        m_cls  <= c_cls;
                        m_mag  <= t_mag;
                        m_lost <= t_lost;
                        m_ge   <= t_ge;
                        m_eq   <= t_eq;
                    end
                end
            end
        end else begin : g_mid_pass
            // Single-stage variant: the shifter feeds the packing directly.
            assign in_ready = out_slot_free;
            assign m_valid  = in_valid;
            assign m_sign   = c_sign;
            assign m_cls    = c_cls;
            assign m_mag    = t_mag;
            assign m_lost   = t_lost;
            assign m_ge     = t_ge;
            assign m_eq     = t_eq;
        end
    endgenerate

    f2i_pack #(.INT_W(INT_W), .FLAG_W(FLAG_W), .Z_BIT(F2I_Z_BIT)) u_pack (
        .sign        (m_sign),
        .cls         (m_cls),
        .mag_low     (m_mag),
        .frac_lost   (m_lost),
        .mag_ge_half (m_ge),
        .mag_eq_half (m_eq),
        .result      (p_result),
        .flags       (p_flags),
        .invalid     (p_invalid),
        .inexact     (p_inexact)
    );

    // Response register: loads when the slot is free, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_flags   <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else if (out_slot_free) begin
            out_valid <= m_valid;
            if (m_valid) begin
                out_result  <= p_result;
                out_flags   <= p_flags;
                out_invalid <= p_invalid;
                out_inexact <= p_inexact;
            end
        end
    end

    // R10: a converted operand reaches the response slot one edge later.
    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && out_slot_free |=> out_valid);

    // R10: a stalled response keeps its contents.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) &&
        $stable(out_flags) && $stable(out_invalid) && $stable(out_inexact));

    // R3: NaN operands give zero and raise invalid.
    p_nan_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && out_slot_free && (m_cls == CL_NAN) |=>
        (out_result == '0) && out_invalid && !out_flags[F2I_Z_BIT]);

    // R4: infinities give zero and raise invalid.
    p_inf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && out_slot_free && (m_cls == CL_INF) |=>
        (out_result == '0) && out_invalid);

    // R7: subnormals give zero and are inexact.
    p_tiny_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && out_slot_free && (m_cls == CL_SUB) |=>
        (out_result == '0) && out_inexact && !out_invalid);

    // R6: exact flag never coexists with an exception indication.
    p_exact_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_flags[F2I_Z_BIT] |-> !out_invalid && !out_inexact);

    // R9: invalid and inexact are mutually exclusive.
    p_one_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));
endmodule

// File: tb/f2i_wrap_conv_tb.sv
module f2i_wrap_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_op = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_result;
    logic [3:0]  out_flags;
    logic        out_invalid;
    logic        out_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    f2i_wrap_conv u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_op       (in_op),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_result  (out_result),
        .out_flags   (out_flags),
        .out_invalid (out_invalid),
        .out_inexact (out_inexact)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input logic [63:0] op);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%h actual=%h expected=%h", tag, op, act, exp);
        end
    endtask

    // Reference: place the significand in a fixed-point word with 136
    // fraction bits and read off integer and fraction parts.
    task automatic ref_model(input logic [63:0] op, output logic [31:0] r,
                             output logic z, output logic inv, output logic inx,
                             output string tag);
        logic [223:0] fx;
        logic [87:0]  ip;
        logic         fnz;
        logic [52:0]  sg;
        logic         neg;
        logic         fits;
        int           e;
        int           ue;
        neg = op[63];
        e   = int'(op[62:52]);
        if (e == 2047) begin
            r = 0; z = 0; inv = 1; inx = 0;
            tag = (op[51:0] != 0) ? "R3" : "R4";
            return;
        end
        sg = {(e != 0), op[51:0]};
        ue = (e == 0) ? -1022 : e - 1023;
        if (ue + 84 < 0) begin
            ip  = '0;
            fnz = |sg;
        end else begin
            fx  = {171'b0, sg} << (ue + 84);
            ip  = fx[223:136];
            fnz = |fx[135:0];
        end
        fits = (ue < 31) || (ue == 31 && neg && ip == 88'h8000_0000);
        r    = (ue >= 84) ? 32'h0 : (neg ? 32'h0 - ip[31:0] : ip[31:0]);
        inv  = !fits;
        inx  = fits && fnz;
        z    = fits && !fnz && !(neg && e == 0 && op[51:0] == 0);
        if (ue >= 84) tag = "R8";
        else if (!fits) tag = "R2";
        else if (ue < 0) tag = "R7";
        else tag = "R1";
    endtask

    task automatic compare_out(input logic [63:0] op);
        logic [31:0] r;
        logic z, inv, inx;
        string tag;
        ref_model(op, r, z, inv, inx, tag);
        check(out_valid == 1'b1, "R10 valid", 64'(out_valid), 64'd1, op);
        check(out_result == r, tag, 64'(out_result), 64'(r), op);
        check((out_flags & 4'b1011) == 4'b0000, "R5", 64'(out_flags), 64'd0, op);
        check(out_flags[2] == z, "R6", 64'(out_flags[2]), 64'(z), op);
        check({out_invalid, out_inexact} == {inv, inx}, "R9",
              64'({out_invalid, out_inexact}), 64'({inv, inx}), op);
    endtask

    // One operand; optionally hold the response for stall cycles.
    task automatic do_op(input logic [63:0] op, input int stall);
        logic [31:0] held;
        @(negedge clk);
        in_op     = op;
        in_valid  = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = (stall == 0);
        compare_out(op);
        if (stall > 0) begin
            held = out_result;
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                check(out_valid && out_result == held && !in_ready, "R10 hold",
                      64'(out_result), 64'(held), op);
            end
            out_ready = 1'b1;
            @(negedge clk);
            check(!out_valid, "R10 drain", 64'(out_valid), 64'd0, op);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] edges [22];
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_result == 0 && out_flags == 0 &&
              !out_invalid && !out_inexact, "R11", 64'(out_result), 64'd0, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 idle ready", 64'(in_ready), 64'd1, 64'd0);

        edges = '{64'h0000000000000000, 64'h8000000000000000,
                  64'h41E0000000000000, 64'hC1E0000000000000,
                  64'h41F0000000000000, 64'hC1F0000000000000,
                  64'h41DFFFFFFFE00000, 64'hC1DFFFFFFFE00000,
                  64'h41E0000000100000, 64'hC1E0000000100000,
                  64'h7FF8000000000001, 64'hFFF0000000000001,
                  64'h7FF0000000000000, 64'hFFF0000000000000,
                  64'h4530000000000000, 64'hC52FFFFFFFFFFFFF,
                  64'h7FEFFFFFFFFFFFFF, 64'h0000000000000001,
                  64'h3FEFFFFFFFFFFFFF, 64'hBFF8000000000000,
                  64'h41EFFFFFFFFFFFFF, 64'hC1EFFFFFFFE00000};
        foreach (edges[i]) do_op(edges[i], (i % 5 == 0) ? 2 : 0);

        // Back-to-back stream: second result one cycle after the first (R10).
        @(negedge clk);
        in_op = 64'h4045000000000000; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        compare_out(64'h4045000000000000);
        in_op = 64'hC1F0000000800000;
        @(negedge clk);
        in_valid = 1'b0;
        compare_out(64'hC1F0000000800000);

        // Sweep every exponent code with several fractions and both signs.
        for (int e = 0; e < 2048; e++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [51:0] m;
                    logic [63:0] hx;
                    hx = 64'(e) * 64'h0009E3779B97F4A7 ^ 64'h5A5A5A5A5A5A;
                    case (p)
                        0: m = '0;
                        1: m = '1;
                        2: m = {1'b1, 50'b0, 1'b1};
                        default: m = hx[51:0];
                    endcase
                    do_op({s[0], e[10:0], m}, ((e + p) % 251 == 0 && s == 1) ? 2 : 0);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule